// File: doc/BRIEF.md
# Shift-and-Add Arithmetic Unit

This block is an 8-bit arithmetic unit. On each enabled clock it does one of two things: a two's-complement addition or subtraction of two operands, or one step of an unsigned shift-and-add multiplication. A single adder does all of this work. The adder is two 4-bit carry-lookahead stages in a chain. Two operand selectors sit in front of it and choose what the adder sees. The A-side selector passes the A operand when direct mode is on or when the current multiplier bit is 1; otherwise it passes zeros. The B-side selector passes one of three values: the B operand, its bitwise inverse, or the registered previous result shifted right by one bit, with the previous carry-out as its top bit.

The caller runs each multiplication. On the first step it raises the feedback-clear input. This loads the multiplier from the B port and ignores the old result. It then issues seven more steps. On every step the caller collects the least significant result bit. After the eighth step, the carry-out and the result together give the upper nine bits of the product. The result port is driven only on cycles that follow a request to drive. Otherwise it reads zero and the drive flag is low.

Top module: `shift_add_alu`

## Requirements
- R1: While reset is held, and until the first enabled step, result, carry_out and overflow are 0 and result_oe is 0.
- R2: With direct_mode=1, invert_b=0 and step_en=1, one cycle later {carry_out, result} equals the 9-bit sum op_a + op_b.
- R3: With direct_mode=1, invert_b=1 and step_en=1, one cycle later result equals op_a - op_b modulo 256. carry_out is 1 exactly when op_a >= op_b as unsigned values.
- R4: In direct mode, overflow is 1 exactly when the signed result is out of range. For an add this means op_a[7]==op_b[7] and result[7]!=op_a[7]. For a subtract it means op_a[7]!=op_b[7] and result[7]!=op_a[7].
- R5: A multiply step (direct_mode=0) with fb_clear=1 gives result = op_a if op_b[0]=1 and result = 0 otherwise, with carry_out=0.
- R6: A multiply takes eight steps: one with fb_clear=1, then seven with fb_clear=0. Take bit k of the product to be result[0] after step k, for k = 0 to 6. After step 7, {carry_out, result} supplies product bits 15 to 7. overflow stays 0 throughout.
- R7: A multiply step with fb_clear=0 takes its multiplier bit from the internally shifted copy of B. The op_b port is ignored on such steps.
- R8: When step_en=0, the result, carry_out, overflow and internal multiplier copy all hold their values, whatever the operands and modes are.
- R9: result_oe one cycle later equals drive_en. While result_oe is 0, result reads 0. carry_out and overflow are not gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a | input | 8 | A operand (multiplicand in multiply) |
| op_b | input | 8 | B operand (multiplier loaded on fb_clear) |
| direct_mode | input | 1 | 1: add/subtract; 0: multiply step |
| invert_b | input | 1 | In direct mode, 1 selects subtraction |
| fb_clear | input | 1 | Zero the feedback path and load the multiplier from op_b |
| step_en | input | 1 | Clock enable for result and multiplier registers |
| drive_en | input | 1 | Request to present the result on the next cycle |
| result | output | 8 | Registered sum, zero when not driven |
| carry_out | output | 1 | Registered adder carry-out |
| overflow | output | 1 | Registered signed overflow (direct mode only) |
| result_oe | output | 1 | Result-valid / drive flag |

## Verification
The hardest state to reach is the middle of a multiplication. There, the B operand that decides the addition is no longer on any port: it is the internal shifted multiplier, and the addend is the carry-extended feedback of the previous step. To get there, the bench runs full eight-step multiplications over many multiplicand/multiplier pairs. From the second step on, it drives the inverted multiplier onto op_b, so a design that still reads the port gives the wrong product. In the middle of every multiplication it also inserts one cycle with step_en low and garbage operands, then checks that the product still comes out correct.

// File: rtl/shift_add_alu_pkg.sv
package shift_add_alu_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned NIB_N  = 2;
  localparam int unsigned DATA_W = NIB_W * NIB_N;

  typedef enum logic [1:0] {
    BSRC_PLAIN    = 2'd0,
    BSRC_INVERTED = 2'd1,
    BSRC_FEEDBACK = 2'd2
  } bsrc_e;
endpackage

// File: rtl/cla_nibble.sv
module cla_nibble #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N-1:0] prop;
  logic [N-1:0] gen;
  logic [N:0]   cy;

  assign prop = a ^ b;
  assign gen  = a & b;

  // every carry formed directly from g/p terms and cin, no ripple
  always_comb begin
    cy[0] = cin;
    for (int j = 0; j < N; j++) begin
      logic acc;
      logic chain;
      acc   = gen[j];
      chain = prop[j];
      for (int k = j - 1; k >= 0; k--) begin
        acc   = acc | (gen[k] & chain);
        chain = chain & prop[k];
      end
      cy[j+1] = acc | (cin & chain);
    end
  end

  assign sum  = prop ^ cy[N-1:0];
  assign cout = cy[N];
endmodule

// File: rtl/cla_chain.sv
module cla_chain #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned NIB_N = 2,
  localparam int unsigned W    = NIB_W * NIB_N
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [NIB_N:0] link;

  assign link[0] = cin;

  for (genvar n = 0; n < NIB_N; n++) begin : g_stage
    cla_nibble #(.N(NIB_W)) u_nib (
      .a    (a[n*NIB_W +: NIB_W]),
      .b    (b[n*NIB_W +: NIB_W]),
      .cin  (link[n]),
      .sum  (sum[n*NIB_W +: NIB_W]),
      .cout (link[n+1])
    );
  end

  assign cout = link[NIB_N];
endmodule

// File: rtl/operand_sel.sv
module operand_sel
  import shift_add_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         mult_bit,
  input  logic [W-1:0] fb_val,
  input  logic         direct_mode,
  input  logic         invert_b,
  input  logic         fb_clear,
  output logic [W-1:0] add_a,
  output logic [W-1:0] add_b,
  output logic         cin
);
  logic  pass_a;
  bsrc_e bsrc;

  assign pass_a = direct_mode | mult_bit;

  always_comb begin
    if (!direct_mode)  bsrc = BSRC_FEEDBACK;
    else if (invert_b) bsrc = BSRC_INVERTED;
    else               bsrc = BSRC_PLAIN;
  end

  always_comb begin
    add_a = pass_a ? op_a : '0;
    unique case (bsrc)
      BSRC_PLAIN:    add_b = op_b;
      BSRC_INVERTED: add_b = ~op_b;
      BSRC_FEEDBACK: add_b = fb_clear ? '0 : fb_val;
      default:       add_b = '0;
    endcase
    cin = (bsrc == BSRC_INVERTED);
  end
endmodule

// File: rtl/shift_add_alu.sv
module shift_add_alu
  import shift_add_alu_pkg::*;
#(
  parameter int unsigned NIB_W = shift_add_alu_pkg::NIB_W,
  parameter int unsigned NIB_N = shift_add_alu_pkg::NIB_N,
  localparam int unsigned W    = NIB_W * NIB_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         direct_mode,
  input  logic         invert_b,
  input  logic         fb_clear,
  input  logic         step_en,
  input  logic         drive_en,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         overflow,
  output logic         result_oe
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  logic [W-1:0] sum_q,  sum_d;
  logic         cy_q,   cy_d;
  logic         ovf_q,  ovf_d;
  logic         oe_q,   oe_d;
  logic [W-1:0] mplr_q, mplr_d;

  // datapath
  logic [W-1:0] mplr_eff;
  logic [W-1:0] fb_val;
  logic [W-1:0] add_a, add_b, add_sum;
  logic         add_cin, add_cout;

  assign mplr_eff = fb_clear ? op_b : mplr_q;
  assign fb_val   = {cy_q, sum_q[W-1:1]};

  operand_sel #(.W(W)) u_sel (
    .op_a        (op_a),
    .op_b        (op_b),
    .mult_bit    (mplr_eff[0]),
    .fb_val      (fb_val),
    .direct_mode (direct_mode),
    .invert_b    (invert_b),
    .fb_clear    (fb_clear),
    .add_a       (add_a),
    .add_b       (add_b),
    .cin         (add_cin)
  );

  cla_chain #(.NIB_W(NIB_W), .NIB_N(NIB_N)) u_add (
    .a    (add_a),
    .b    (add_b),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout)
  );

  // next state
  always_comb begin
    sum_d  = sum_q;
    cy_d   = cy_q;
    ovf_d  = ovf_q;
    mplr_d = mplr_q;
    oe_d   = drive_en;
    if (step_en) begin
      sum_d = add_sum;
      cy_d  = add_cout;
      ovf_d = direct_mode & (add_a[W-1] == add_b[W-1]) & (add_sum[W-1] != add_a[W-1]);
      if (!direct_mode) mplr_d = {1'b0, mplr_eff[W-1:1]};
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sum_q  <= '0;
      cy_q   <= 1'b0;
      ovf_q  <= 1'b0;
      oe_q   <= 1'b0;
      mplr_q <= '0;
    end else begin
      sum_q  <= sum_d;
      cy_q   <= cy_d;
      ovf_q  <= ovf_d;
      oe_q   <= oe_d;
      mplr_q <= mplr_d;
    end
  end

  assign result    = oe_q ? sum_q : '0;
  assign carry_out = cy_q;
  assign overflow  = ovf_q;
  assign result_oe = oe_q;
endmodule

// File: rtl/shift_add_alu_chk.sv
module shift_add_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         direct_mode,
  input logic         invert_b,
  input logic         fb_clear,
  input logic         step_en,
  input logic         drive_en,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         overflow,
  input logic         result_oe
);
  assert_add_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_mode && !invert_b && step_en && drive_en) |=>
      ({carry_out, result} == (W+1)'({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

  assert_sub_diff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_mode && invert_b && step_en && drive_en) |=>
      ({carry_out, result} == (W+1)'({1'b0, $past(op_a)} + {1'b0, ~$past(op_b)} + 1)));

  assert_first_step_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct_mode && fb_clear && step_en) |=> !carry_out);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct_mode && step_en) |=> !overflow);

  assert_hold_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(carry_out) && $stable(overflow)));

  assert_undriven_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |=> (!result_oe && result == '0));
endmodule

bind shift_add_alu shift_add_alu_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_a        (op_a),
  .op_b        (op_b),
  .direct_mode (direct_mode),
  .invert_b    (invert_b),
  .fb_clear    (fb_clear),
  .step_en     (step_en),
  .drive_en    (drive_en),
  .result      (result),
  .carry_out   (carry_out),
  .overflow    (overflow),
  .result_oe   (result_oe)
);

// File: tb/shift_add_alu_test.sv
module shift_add_alu_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] op_a, op_b;
  logic       direct_mode, invert_b, fb_clear, step_en, drive_en;
  logic [7:0] result;
  logic       carry_out, overflow, result_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  shift_add_alu uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .direct_mode(direct_mode), .invert_b(invert_b), .fb_clear(fb_clear),
    .step_en(step_en), .drive_en(drive_en), .result(result),
    .carry_out(carry_out), .overflow(overflow), .result_oe(result_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic dm,
                       input logic inv, input logic clr, input logic se, input logic de);
    op_a = a; op_b = b; direct_mode = dm; invert_b = inv;
    fb_clear = clr; step_en = se; drive_en = de;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog all requirements actual=%0d expected<190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; direct_mode = 1'b0; invert_b = 1'b0;
    fb_clear = 1'b0; step_en = 1'b0; drive_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 result", result, 0);
    check("R1 carry", carry_out, 0);
    check("R1 overflow", overflow, 0);
    check("R1 oe", result_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release result", result, 0);
    check("R1 after release oe", result_oe, 0);

    // R2, R3, R4, R9: add / subtract sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 3) begin
        for (int s = 0; s < 2; s++) begin
          int  full, sa, sb, sr;
          logic de, ov;
          de = ((a + b + s) % 5) != 0;
          drive(8'(a), 8'(b), 1'b1, s[0], 1'b0, 1'b1, de);
          sa = a > 127 ? a - 256 : a;
          sb = b > 127 ? b - 256 : b;
          sr = s ? sa - sb : sa + sb;
          ov = (sr > 127) || (sr < -128);
          if (s == 0) begin
            full = a + b;
            check("R2 carry", carry_out, full >> 8);
            if (de) check("R2 sum", result, full & 255);
          end else begin
            check("R3 carry", carry_out, (a >= b) ? 1 : 0);
            if (de) check("R3 diff", result, (a - b) & 255);
          end
          check("R4 overflow", overflow, ov);
          check("R9 oe", result_oe, de);
          if (!de) check("R9 undriven result", result, 0);
        end
      end
    end

    // R5, R6, R7, R8: full multiplications
    for (int a = 0; a < 256; a += 7) begin
      for (int b = 0; b < 256; b++) begin
        int prod;
        int got;
        logic [7:0] held;
        logic       held_c;
        prod = a * b;
        got  = 0;
        drive(8'(a), 8'(b), 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R5 first step", result, (b & 1) ? a : 0);
        check("R5 first carry", carry_out, 0);
        got = got | int'(result[0]);
        for (int k = 1; k < 8; k++) begin
          if (k == 4) begin
            held = result; held_c = carry_out;
            drive(~8'(a), 8'hA5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
            check("R8 hold result", result, held);
            check("R8 hold carry", carry_out, held_c);
          end
          // R7: op_b carries the wrong value on later steps
          drive(8'(a), ~8'(b), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
          check("R6 overflow", overflow, 0);
          if (k < 7) got = got | (int'(result[0]) << k);
        end
        got = got | (int'({carry_out, result}) << 7);
        check("R6 R7 product", got, prod);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule